// File: doc/BRIEF.md
# Prioritized Interrupt Controller with DMA Routing

This block gathers event pulses from a set of peripheral sources (factors), latches each one in a factor flag, and presents the CPU with a single prioritized interrupt request, its level and the index of the winning factor. Factors are organised in interrupt systems. Each system shares one 3-bit priority field, so eight distinct levels exist even though the CPU's current interrupt level is four bits wide. A request is raised only when the winner's priority is strictly above that CPU level.

Each factor can instead be routed to a DMA channel. A routed event raises a DMA trigger bit and leaves the CPU flag alone. The DMA engine reports completion per factor, and the flag is set only if the engine has the completion interrupt enabled. A style pin picks the software clearing semantics. In one style, factor flags are cleared by writing ones and the DMA registers are set by writing ones. In the other, the written value is stored directly. A wake output tells the power controller to leave standby or sleep whenever an enabled flag or a DMA trigger is pending.

Top module: `prio_intc`

## Requirements
- R1: After reset every register (flags at address 0, CPU enables at 1, DMA route at 2, DMA trigger at 3, priorities at 4) reads 0, and irq_o, wake_o and dma_req_o are 0.
- R2: An evt_i pulse on a factor whose route bit is 0 sets its flag at that clock edge, and the flag stays set until software clears it.
- R3: With rw_style_i = 0, a write to address 0 clears each flag whose write-data bit is 1 and leaves flags written with 0 unchanged.
- R4: With rw_style_i = 1, a write to address 0 clears each flag written with 0 and sets each flag written with 1.
- R5: A hardware set of a flag in the same cycle as a software clear of that flag leaves the flag set.
- R6: With rw_style_i = 0, writes to address 2 or 3 set the bits written with 1 and ignore bits written with 0. With rw_style_i = 1, they store the written value. A dma_ack_i pulse clears that factor's trigger bit.
- R7: An evt_i pulse on a factor whose route bit is 1 sets its trigger bit, which appears on dma_req_o, and does not set its flag.
- R8: A dma_done_i pulse sets the factor's flag only when dma_done_ien_i for that factor is 1. Otherwise the flag is unchanged.
- R9: Address 4 holds one 3-bit priority per system, with system s at bits 3s+2..3s. Factor i belongs to system i / SRC_PER_SYS.
- R10: irq_o is 1 only when the winning priority is strictly greater than cpu_il_i (0..15). Priority 0 therefore never interrupts. irq_lvl_o carries the winning priority.
- R11: A factor is pending when its flag and its CPU enable bit are both 1. The winner is the pending factor with the highest priority, and ties go to the lowest index. irq_vec_o carries the winner's index. These outputs are registered and follow the state one clock later.
- R12: wake_o is 1 whenever any pending factor or any DMA trigger bit exists, and it follows the state in the same cycle.
- R13: A read strobe loads bus_rdata_o at the clock edge, and the value holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rw_style_i | input | 1 | 0: clear-by-one / set-by-one, 1: direct read/write |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DW (12) | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | DW (12) | Read data, one cycle after the strobe |
| evt_i | input | N (8) | Per-factor event pulses |
| dma_done_i | input | N (8) | Per-factor DMA completion pulses |
| dma_done_ien_i | input | N (8) | Per-factor completion interrupt enable from the DMA side |
| dma_ack_i | input | N (8) | Per-factor DMA trigger acknowledge |
| dma_req_o | output | N (8) | Per-factor DMA trigger bits |
| cpu_il_i | input | 4 | CPU current interrupt level |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_lvl_o | output | 3 | Priority of the request |
| irq_vec_o | output | VW (3) | Index of the winning factor |
| wake_o | output | 1 | Wake request for low-power modes |

## Verification
Flag, route and trigger bits change at the clock edge that samples the event or write. A register read therefore shows them once the following read strobe has been clocked. wake_o is valid right after that same edge. The arbiter outputs irq_o, irq_lvl_o and irq_vec_o are due one edge later. The bench drives every stimulus on the falling edge, lets the required number of rising edges pass, and samples on a later falling edge. The priority sweep forces flag patterns with direct writes and always waits one extra edge before it compares the arbiter results against a level-by-level model.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

  typedef enum logic [2:0] {
    RA_FLAG  = 3'd0,
    RA_IEN   = 3'd1,
    RA_ROUTE = 3'd2,
    RA_DREQ  = 3'd3,
    RA_PRIO  = 3'd4
  } ictl_addr_e;

  typedef enum logic {
    CLR_ONE = 1'b0,
    CLR_RW  = 1'b1
  } clr_style_e;

  localparam int PRIO_W = 3;

  // Software clear of a factor flag for a given write bit and style.
  function automatic logic flag_clear_hit(clr_style_e st, logic wbit);
    return (st == CLR_ONE) ? wbit : ~wbit;
  endfunction

  // Software set of a factor flag (only the direct style may set).
  function automatic logic flag_set_hit(clr_style_e st, logic wbit);
    return (st == CLR_RW) & wbit;
  endfunction

  // System owning a factor index.
  function automatic int sys_of(int idx, int per_sys);
    return idx / per_sys;
  endfunction

endpackage

// File: rtl/ictl_src.sv
module ictl_src
  import ictl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  clr_style_e style_i,
  input  logic       evt_i,
  input  logic       done_i,
  input  logic       done_ien_i,
  input  logic       ack_i,
  input  logic       wr_flag_i,
  input  logic       wr_route_i,
  input  logic       wr_dreq_i,
  input  logic       wbit_i,
  output logic       flag_o,
  output logic       route_o,
  output logic       dreq_o
);

  logic flag_q, route_q, dreq_q;

  logic hw_flag_set, sw_flag_set, sw_flag_clr;
  logic hw_dreq_set, sw_dreq_set, sw_dreq_clr;

  assign hw_flag_set = (evt_i & ~route_q) | (done_i & done_ien_i);
  assign sw_flag_set = wr_flag_i & flag_set_hit(style_i, wbit_i);
  assign sw_flag_clr = wr_flag_i & flag_clear_hit(style_i, wbit_i);

  assign hw_dreq_set = evt_i & route_q;
  assign sw_dreq_set = wr_dreq_i & wbit_i;
  assign sw_dreq_clr = wr_dreq_i & (style_i == CLR_RW) & ~wbit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (hw_flag_set | sw_flag_set) begin
      flag_q <= 1'b1;
    end else if (sw_flag_clr) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q <= 1'b0;
    end else if (wr_route_i) begin
      if (style_i == CLR_RW) begin
        route_q <= wbit_i;
      end else if (wbit_i) begin
        route_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreq_q <= 1'b0;
    end else if (hw_dreq_set | sw_dreq_set) begin
      dreq_q <= 1'b1;
    end else if (sw_dreq_clr | ack_i) begin
      dreq_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign route_o = route_q;
  assign dreq_o  = dreq_q;

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !route_q) |=> flag_q); // R5

  AST_ROUTED_TO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && route_q) |=> dreq_q); // R7

  AST_DONE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !done_ien_i && !evt_i && !wr_flag_i && !flag_q) |=> !flag_q); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !evt_i && !wr_dreq_i) |=> !dreq_q); // R6

endmodule

// File: rtl/ictl_regbank.sv
module ictl_regbank
  import ictl_pkg::*;
#(
  parameter int N       = 8,
  parameter int NUM_SYS = 4,
  parameter int DW      = 12,
  parameter int AW      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic [N-1:0]            flags_i,
  input  logic [N-1:0]            route_i,
  input  logic [N-1:0]            dreq_i,
  output logic                    wr_flag_o,
  output logic                    wr_route_o,
  output logic                    wr_dreq_o,
  output logic [N-1:0]            ien_o,
  output logic [NUM_SYS*PRIO_W-1:0] prio_o,
  output logic [DW-1:0]           rdata_o,
  output logic                    wake_o
);

  localparam int PW = NUM_SYS * PRIO_W;

  logic [N-1:0]  ien_q;
  logic [PW-1:0] prio_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rd_mux;
  logic          wr_ien, wr_prio;

  assign wr_flag_o  = we_i && (addr_i == AW'(RA_FLAG));
  assign wr_ien     = we_i && (addr_i == AW'(RA_IEN));
  assign wr_route_o = we_i && (addr_i == AW'(RA_ROUTE));
  assign wr_dreq_o  = we_i && (addr_i == AW'(RA_DREQ));
  assign wr_prio    = we_i && (addr_i == AW'(RA_PRIO));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q  <= '0;
      prio_q <= '0;
    end else begin
      if (wr_ien)  ien_q  <= wdata_i[N-1:0];
      if (wr_prio) prio_q <= wdata_i[PW-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      AW'(RA_FLAG):  rd_mux = DW'(flags_i);
      AW'(RA_IEN):   rd_mux = DW'(ien_q);
      AW'(RA_ROUTE): rd_mux = DW'(route_i);
      AW'(RA_DREQ):  rd_mux = DW'(dreq_i);
      AW'(RA_PRIO):  rd_mux = DW'(prio_q);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (re_i) begin
      rdata_q <= rd_mux;
    end
  end

  assign ien_o   = ien_q;
  assign prio_o  = prio_q;
  assign rdata_o = rdata_q;
  assign wake_o  = (|(flags_i & ien_q)) | (|dreq_i);

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !re_i |=> $stable(rdata_q)); // R13

endmodule

// File: rtl/ictl_arb.sv
module ictl_arb
  import ictl_pkg::*;
#(
  parameter int N       = 8,
  parameter int NUM_SYS = 4,
  parameter int SRC_PER_SYS = 2,
  parameter int VW      = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              pend_i,
  input  logic [NUM_SYS*PRIO_W-1:0] prio_i,
  input  logic [3:0]                cpu_il_i,
  output logic                      irq_o,
  output logic [PRIO_W-1:0]         irq_lvl_o,
  output logic [VW-1:0]             irq_vec_o
);

  logic [PRIO_W-1:0] lvl_of [N];
  logic              win_found;
  logic [PRIO_W-1:0] win_lvl;
  logic [VW-1:0]     win_idx;
  logic              win_above;

  logic              irq_q;
  logic [PRIO_W-1:0] lvl_q;
  logic [VW-1:0]     vec_q;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    localparam int SYS = sys_of(g, SRC_PER_SYS);
    assign lvl_of[g] = prio_i[SYS*PRIO_W +: PRIO_W];
  end

  // Strictly-greater update keeps the lowest index among equal levels.
  always_comb begin
    win_found = 1'b0;
    win_lvl   = '0;
    win_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && (!win_found || (lvl_of[i] > win_lvl))) begin
        win_found = 1'b1;
        win_lvl   = lvl_of[i];
        win_idx   = VW'(i);
      end
    end
  end

  assign win_above = win_found && ({1'b0, win_lvl} > cpu_il_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      irq_q <= win_above;
      lvl_q <= win_lvl;
      vec_q <= win_idx;
    end
  end

  assign irq_o     = irq_q;
  assign irq_lvl_o = lvl_q;
  assign irq_vec_o = vec_q;

  AST_IRQ_ABOVE_IL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ({1'b0, irq_lvl_o} > $past(cpu_il_i))); // R10

  AST_IRQ_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(pend_i) != '0)); // R11

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import ictl_pkg::*;
#(
  parameter int NUM_SYS     = 4,
  parameter int SRC_PER_SYS = 2,
  localparam int N  = NUM_SYS * SRC_PER_SYS,
  localparam int DW = (NUM_SYS * PRIO_W > N) ? NUM_SYS * PRIO_W : N,
  localparam int VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rw_style_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic [N-1:0]      evt_i,
  input  logic [N-1:0]      dma_done_i,
  input  logic [N-1:0]      dma_done_ien_i,
  input  logic [N-1:0]      dma_ack_i,
  output logic [N-1:0]      dma_req_o,
  input  logic [3:0]        cpu_il_i,
  output logic              irq_o,
  output logic [PRIO_W-1:0] irq_lvl_o,
  output logic [VW-1:0]     irq_vec_o,
  output logic              wake_o
);

  clr_style_e                 style;
  logic [N-1:0]               flags, route, dreq, ien, pend;
  logic                       wr_flag, wr_route, wr_dreq;
  logic [NUM_SYS*PRIO_W-1:0]  prio;

  assign style = clr_style_e'(rw_style_i);

  for (genvar g = 0; g < N; g++) begin : g_src
    ictl_src u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .style_i    (style),
      .evt_i      (evt_i[g]),
      .done_i     (dma_done_i[g]),
      .done_ien_i (dma_done_ien_i[g]),
      .ack_i      (dma_ack_i[g]),
      .wr_flag_i  (wr_flag),
      .wr_route_i (wr_route),
      .wr_dreq_i  (wr_dreq),
      .wbit_i     (bus_wdata_i[g]),
      .flag_o     (flags[g]),
      .route_o    (route[g]),
      .dreq_o     (dreq[g])
    );
  end

  ictl_regbank #(
    .N       (N),
    .NUM_SYS (NUM_SYS),
    .DW      (DW),
    .AW      (3)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .we_i       (bus_we_i),
    .re_i       (bus_re_i),
    .flags_i    (flags),
    .route_i    (route),
    .dreq_i     (dreq),
    .wr_flag_o  (wr_flag),
    .wr_route_o (wr_route),
    .wr_dreq_o  (wr_dreq),
    .ien_o      (ien),
    .prio_o     (prio),
    .rdata_o    (bus_rdata_o),
    .wake_o     (wake_o)
  );

  assign pend = flags & ien;

  ictl_arb #(
    .N           (N),
    .NUM_SYS     (NUM_SYS),
    .SRC_PER_SYS (SRC_PER_SYS),
    .VW          (VW)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend),
    .prio_i    (prio),
    .cpu_il_i  (cpu_il_i),
    .irq_o     (irq_o),
    .irq_lvl_o (irq_lvl_o),
    .irq_vec_o (irq_vec_o)
  );

  assign dma_req_o = dreq;

  AST_WAKE_ON_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_req_o) |-> wake_o); // R12

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && (dma_req_o == '0))); // R1

endmodule

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;

  localparam int N   = 8;
  localparam int DW  = 12;
  localparam logic [2:0] A_FLAG = 3'd0, A_IEN = 3'd1, A_ROUTE = 3'd2,
                         A_DREQ = 3'd3, A_PRIO = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rw_style = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [DW-1:0] rdata;
  logic [N-1:0] evt = '0, done = '0, done_ien = '0, ack = '0;
  logic [N-1:0] dma_req;
  logic [3:0] cpu_il = '0;
  logic irq;
  logic [2:0] irq_lvl;
  logic [2:0] irq_vec;
  logic wake;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .rw_style_i(rw_style),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_re_i(re),
    .bus_rdata_o(rdata), .evt_i(evt), .dma_done_i(done),
    .dma_done_ien_i(done_ien), .dma_ack_i(ack), .dma_req_o(dma_req),
    .cpu_il_i(cpu_il), .irq_o(irq), .irq_lvl_o(irq_lvl),
    .irq_vec_o(irq_vec), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d;
    rd(a, d);
    chk(req, 32'(d), 32'(exp));
  endtask

  task automatic pulse_evt(input logic [N-1:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  // Independent model: scan levels from the top, first index per level.
  task automatic model(input logic [N-1:0] pend, input logic [11:0] pr,
                       input logic [3:0] il, output bit e_irq,
                       output logic [2:0] e_lvl, output logic [2:0] e_vec);
    e_irq = 1'b0; e_lvl = '0; e_vec = '0;
    for (int l = 7; l >= 1; l--) begin
      if (!e_irq && (l > int'(il))) begin
        for (int i = 0; i < N; i++) begin
          if (!e_irq && pend[i] && (int'(pr[3*(i/2) +: 3]) == l)) begin
            e_irq = 1'b1; e_lvl = 3'(l); e_vec = 3'(i);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 flag", A_FLAG, '0);
    rd_chk("R1 ien", A_IEN, '0);
    rd_chk("R1 route", A_ROUTE, '0);
    rd_chk("R1 dreq", A_DREQ, '0);
    rd_chk("R1 prio", A_PRIO, '0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 wake", 32'(wake), 0);
    chk("R1 dma_req", 32'(dma_req), 0);

    // R2 events set flags, and they persist
    rw_style = 1'b0;
    for (int i = 0; i < N; i++) begin
      pulse_evt(N'(1) << i);
      rd_chk("R2 set", A_FLAG, DW'((1 << (i + 1)) - 1));
    end
    repeat (5) @(negedge clk);
    rd_chk("R2 persist", A_FLAG, DW'(8'hFF));

    // R3 clear-by-one style
    wr(A_FLAG, DW'(8'h55));
    rd_chk("R3 ones clear", A_FLAG, DW'(8'hAA));
    wr(A_FLAG, '0);
    rd_chk("R3 zeros ignored", A_FLAG, DW'(8'hAA));
    wr(A_FLAG, DW'(8'hFF));
    rd_chk("R3 clear all", A_FLAG, '0);

    // R4 direct style
    rw_style = 1'b1;
    wr(A_FLAG, DW'(8'h3C));
    rd_chk("R4 ones set", A_FLAG, DW'(8'h3C));
    wr(A_FLAG, DW'(8'h0C));
    rd_chk("R4 zeros clear", A_FLAG, DW'(8'h0C));
    wr(A_FLAG, DW'(8'hFF));

    // R5 hardware set beats software clear in the same cycle
    rw_style = 1'b0;
    @(negedge clk);
    addr = A_FLAG; wdata = DW'(8'hFF); we = 1'b1; evt = 8'h08;
    @(negedge clk);
    we = 1'b0; evt = '0;
    rd_chk("R5 clear-by-one", A_FLAG, DW'(8'h08));
    rw_style = 1'b1;
    @(negedge clk);
    addr = A_FLAG; wdata = '0; we = 1'b1; evt = 8'h20;
    @(negedge clk);
    we = 1'b0; evt = '0;
    rd_chk("R5 direct", A_FLAG, DW'(8'h20));
    wr(A_FLAG, '0);

    // R6 route / trigger register styles and acknowledge
    rw_style = 1'b0;
    wr(A_ROUTE, DW'(8'h03));
    rd_chk("R6 route set", A_ROUTE, DW'(8'h03));
    wr(A_ROUTE, DW'(8'h04));
    rd_chk("R6 route accum", A_ROUTE, DW'(8'h07));
    wr(A_ROUTE, '0);
    rd_chk("R6 route zero ignored", A_ROUTE, DW'(8'h07));
    rw_style = 1'b1;
    wr(A_ROUTE, DW'(8'h11));
    rd_chk("R6 route direct", A_ROUTE, DW'(8'h11));
    rw_style = 1'b0;
    wr(A_DREQ, DW'(8'h80));
    chk("R6 dreq set", 32'(dma_req), 32'h80);
    @(negedge clk); ack = 8'h80;
    @(negedge clk); ack = '0;
    chk("R6 ack clears", 32'(dma_req), 0);

    // R7 routed events go to DMA, not to the flag
    pulse_evt(8'h13);
    chk("R7 dma_req", 32'(dma_req), 32'h11);
    rd_chk("R7 flag", A_FLAG, DW'(8'h02));
    chk("R12 wake on dreq", 32'(wake), 1);
    @(negedge clk); ack = 8'h11;
    @(negedge clk); ack = '0;
    rd_chk("R7 dreq after ack", A_DREQ, '0);
    rw_style = 1'b1;
    wr(A_ROUTE, '0);
    wr(A_FLAG, '0);

    // R8 completion reaches the flag only when enabled
    @(negedge clk); done = 8'h0F; done_ien = 8'h05;
    @(negedge clk); done = '0; done_ien = '0;
    rd_chk("R8 done gated", A_FLAG, DW'(8'h05));

    // R12 wake follows enabled flags
    chk("R12 wake masked", 32'(wake), 0);
    wr(A_IEN, DW'(8'h04));
    chk("R12 wake enabled", 32'(wake), 1);
    wr(A_FLAG, '0);
    chk("R12 wake cleared", 32'(wake), 0);

    // R13 read data holds without a strobe
    rd_chk("R13 read", A_FLAG, '0);
    pulse_evt(8'h01);
    repeat (2) @(negedge clk);
    chk("R13 hold", 32'(rdata), 0);
    rd_chk("R13 refresh", A_FLAG, DW'(8'h01));
    wr(A_FLAG, '0);

    // R9 priority field readback
    wr(A_PRIO, DW'(12'hFAC));
    rd_chk("R9 prio", A_PRIO, DW'(12'hFAC));

    // R10 / R11 sweep over patterns, priority sets and CPU levels
    for (int c = 0; c < 4; c++) begin
      logic [11:0] pr;
      logic [N-1:0] ien_v;
      for (int s = 0; s < 4; s++) pr[3*s +: 3] = 3'((s * 3 + c * 5 + 1) % 8);
      if (c == 3) pr[5:3] = pr[2:0];
      ien_v = (c == 1) ? 8'h5A : 8'hFF;
      wr(A_PRIO, pr);
      wr(A_IEN, DW'(ien_v));
      for (int k = 0; k < 5; k++) begin
        cpu_il = 4'(k * 2);
        for (int p = 0; p < 256; p++) begin
          bit e_irq;
          logic [2:0] e_lvl, e_vec;
          logic [N-1:0] pend;
          wr(A_FLAG, DW'(p));
          pend = N'(p) & ien_v;
          chk("R12 wake sweep", 32'(wake), 32'(|pend));
          @(negedge clk);
          model(pend, pr, cpu_il, e_irq, e_lvl, e_vec);
          chk("R10 irq", 32'(irq), 32'(e_irq));
          if (e_irq) begin
            chk("R10 lvl", 32'(irq_lvl), 32'(e_lvl));
            chk("R11 vec", 32'(irq_vec), 32'(e_vec));
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule